// File: doc/BRIEF.md
# Power-Good and Reset Sequencer

This block sits on the SoC side of a security subsystem and brings that subsystem up in a fixed order. It runs from a free-running clock. It first enables the subsystem clock. After a minimum number of cycles it raises power-good. After a further minimum number of cycles it releases the subsystem's active-low core reset. Both gaps are parameters. Any value below ten is raised to ten, so an integrator cannot configure a sequence shorter than the floor.

The SoC cold-boot reset sets every output to its off value at once, without waiting for a clock edge. Power-good therefore follows the cold-boot reset. A separate warm-reset input puts only the core reset back into reset and leaves power-good high. When the warm reset is released, the block runs the second wait again before it lets the core reset go. The core reset always goes low asynchronously and always returns high through a two-flop synchronizer on the clock.

Top module: `boot_pwr_seq`

## Requirements
- R1: On the first rising clock edge at which `cold_rst_ni` is high, `clk_en_o` goes to 1. It stays at 1 until the next cold reset.
- R2: `pwr_good_o` rises on the WARMUP_CYCLES-th rising edge after the edge that raised `clk_en_o`. With the default parameters this is the eleventh edge after the cold reset is released.
- R3: `core_rst_no` rises on the (HOLD_CYCLES+2)-th rising edge after the edge that raised `pwr_good_o`. HOLD_CYCLES of these edges are the hold count and two are the release synchronizer.
- R4: While `cold_rst_ni` is 0, `clk_en_o`, `pwr_good_o` and `core_rst_no` are all 0. This takes effect as soon as the input falls, without a clock edge.
- R5: While `warm_rst_ni` is 0, `core_rst_no` is 0. It falls with no clock edge. `pwr_good_o` and `clk_en_o` keep the value 1 that they had.
- R6: After `warm_rst_ni` returns to 1, `core_rst_no` rises on the (HOLD_CYCLES+2)-th rising edge counted from the first edge at which `warm_rst_ni` is high.
- R7: A warm reset that is applied and released before `pwr_good_o` rises has no effect on when `pwr_good_o` rises or when `core_rst_no` rises.
- R8: A WARMUP_CYCLES or HOLD_CYCLES value below 10 behaves exactly like the value 10.
- R9: `core_rst_no` is never 1 while `pwr_good_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running sequencer clock |
| cold_rst_ni | input | 1 | SoC cold-boot reset, active low, asynchronous assert |
| warm_rst_ni | input | 1 | Warm reset request for the core only, active low |
| clk_en_o | output | 1 | Clock enable for the subsystem |
| pwr_good_o | output | 1 | Power-good to the subsystem |
| core_rst_no | output | 1 | Core reset to the subsystem, active low |

## Verification
The clocked properties assume that `cold_rst_ni` and `warm_rst_ni` change away from the rising clock edge. The properties that look at edges of `pwr_good_o` and `core_rst_no` also assume that the block is out of cold reset. The stimulus keeps to these assumptions by changing every input one nanosecond after a rising edge. It also holds each reset for at least two edges. The only warm pulses it applies come either after the full sequence has finished or during the clock warm-up.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Shortest legal gap between sequencing events, in clock cycles.
    localparam int unsigned MIN_GAP = 10;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_WARMUP  = 2'd1,
        ST_PG_WAIT = 2'd2,
        ST_RUN     = 2'd3
    } seq_state_e;

    function automatic int unsigned clamp_min(int unsigned val, int unsigned floor_val);
        return (val < floor_val) ? floor_val : val;
    endfunction

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int unsigned WARMUP = 10,
    parameter int unsigned HOLD   = 10,
    parameter int unsigned CNT_W  = 4
) (
    input  logic clk_i,
    input  logic cold_rst_ni,
    input  logic warm_rst_ni,
    output logic clk_en_o,
    output logic pwr_good_o,
    output logic run_o
);

    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARMUP - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             clk_en;
        logic             pg;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: ST_OFF, cnt: '0, clk_en: 1'b0, pg: 1'b0};

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_OFF: begin
                fsm_d.st     = ST_WARMUP;
                fsm_d.clk_en = 1'b1;
                fsm_d.cnt    = '0;
            end
            ST_WARMUP: begin
                if (fsm_q.cnt == WARM_LAST) begin
                    fsm_d.st  = ST_PG_WAIT;
                    fsm_d.pg  = 1'b1;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_PG_WAIT: begin
                if (!warm_rst_ni) begin
                    fsm_d.cnt = '0;
                end else if (fsm_q.cnt == HOLD_LAST) begin
                    fsm_d.st  = ST_RUN;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (!warm_rst_ni) begin
                    fsm_d.st  = ST_PG_WAIT;
                    fsm_d.cnt = '0;
                end
            end
            default: fsm_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge cold_rst_ni) begin
        if (!cold_rst_ni) fsm_q <= FSM_RST;
        else              fsm_q <= fsm_d;
    end

    assign clk_en_o   = fsm_q.clk_en;
    assign pwr_good_o = fsm_q.pg;
    assign run_o      = (fsm_q.st == ST_RUN);

    // Independent tally of enabled clock cycles, used only by the check below.
    logic [CNT_W:0] en_cycles_d, en_cycles_q;

    always_comb begin
        en_cycles_d = en_cycles_q;
        if (clk_en_o && (en_cycles_q < (CNT_W+1)'(WARMUP))) en_cycles_d = en_cycles_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge cold_rst_ni) begin
        if (!cold_rst_ni) en_cycles_q <= '0;
        else              en_cycles_q <= en_cycles_d;
    end

    p_pg_after_warmup_r2: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
        $rose(pwr_good_o) |-> (en_cycles_q >= (CNT_W+1)'(WARMUP)));

    p_warm_keeps_pg_r5: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
        (!warm_rst_ni && $past(pwr_good_o)) |-> pwr_good_o);

endmodule

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic release_i,
    output logic rst_no
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = release_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], release_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q <= '0;
        else          chain_q <= chain_d;
    end

    assign rst_no = chain_q[STAGES-1];

    p_release_after_req_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(rst_no) |-> $past(release_i));

endmodule

// File: rtl/boot_pwr_seq.sv
module boot_pwr_seq #(
    parameter int unsigned WARMUP_CYCLES = 10,
    parameter int unsigned HOLD_CYCLES   = 10,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk_i,
    input  logic cold_rst_ni,
    input  logic warm_rst_ni,
    output logic clk_en_o,
    output logic pwr_good_o,
    output logic core_rst_no
);

    localparam int unsigned WARM_EFF = seq_pkg::clamp_min(WARMUP_CYCLES, seq_pkg::MIN_GAP);
    localparam int unsigned HOLD_EFF = seq_pkg::clamp_min(HOLD_CYCLES, seq_pkg::MIN_GAP);
    localparam int unsigned GAP_MAX  = (WARM_EFF > HOLD_EFF) ? WARM_EFF : HOLD_EFF;
    localparam int unsigned CNT_W    = $clog2(GAP_MAX);

    logic run;
    logic sync_arst_n;

    // Either reset source pulls the core reset low at once.
    assign sync_arst_n = cold_rst_ni & warm_rst_ni;

    seq_fsm #(
        .WARMUP (WARM_EFF),
        .HOLD   (HOLD_EFF),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .cold_rst_ni (cold_rst_ni),
        .warm_rst_ni (warm_rst_ni),
        .clk_en_o    (clk_en_o),
        .pwr_good_o  (pwr_good_o),
        .run_o       (run)
    );

    rst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_rst_sync (
        .clk_i     (clk_i),
        .arst_ni   (sync_arst_n),
        .release_i (run),
        .rst_no    (core_rst_no)
    );

    // Cycles spent with power-good high, saturating; feeds the gap check only.
    logic [CNT_W:0] pg_cycles_d, pg_cycles_q;

    always_comb begin
        pg_cycles_d = pg_cycles_q;
        if (!pwr_good_o)                                 pg_cycles_d = '0;
        else if (pg_cycles_q < (CNT_W+1)'(HOLD_EFF))     pg_cycles_d = pg_cycles_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge cold_rst_ni) begin
        if (!cold_rst_ni) pg_cycles_q <= '0;
        else              pg_cycles_q <= pg_cycles_d;
    end

    p_rst_after_hold_r3: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
        $rose(core_rst_no) |-> (pg_cycles_q >= (CNT_W+1)'(HOLD_EFF)));

    p_cold_drops_all_r4: assert property (@(posedge clk_i)
        !cold_rst_ni |-> (!clk_en_o && !pwr_good_o && !core_rst_no));

    p_warm_holds_core_r5: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
        !warm_rst_ni |-> !core_rst_no);

    p_rst_needs_pg_r9: assert property (@(posedge clk_i) disable iff (!cold_rst_ni)
        core_rst_no |-> pwr_good_o);

endmodule

// File: tb/boot_pwr_seq_bench.sv
module boot_pwr_seq_bench;

    localparam int W  = 12;
    localparam int H  = 14;
    localparam int CW = 10;   // clamped instance: effective values
    localparam int CH = 10;

    logic clk = 1'b0;
    logic cold_rst_n = 1'b1;
    logic warm_rst_n = 1'b1;
    logic ce, pg, rst_n;
    logic c_ce, c_pg, c_rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    boot_pwr_seq #(.WARMUP_CYCLES(W), .HOLD_CYCLES(H)) u_boot_pwr_seq (
        .clk_i(clk), .cold_rst_ni(cold_rst_n), .warm_rst_ni(warm_rst_n),
        .clk_en_o(ce), .pwr_good_o(pg), .core_rst_no(rst_n));

    boot_pwr_seq #(.WARMUP_CYCLES(3), .HOLD_CYCLES(5)) u_clamped (
        .clk_i(clk), .cold_rst_ni(cold_rst_n), .warm_rst_ni(warm_rst_n),
        .clk_en_o(c_ce), .pwr_good_o(c_pg), .core_rst_no(c_rst_n));

    typedef struct {
        bit    ce, pg, rst, cpg, crst;
        string pg_tag, rst_tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input logic act, input bit exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected outputs per falling edge after a cold release; index 0 precedes the first rising edge.
    task automatic push_cold(input string pg_tag);
        for (int j = 0; j <= W + H + 5; j++) begin
            exp_t e;
            e.ce   = (j >= 1);
            e.pg   = (j >= W + 1);
            e.rst  = (j >= W + H + 3);
            e.cpg  = (j >= CW + 1);
            e.crst = (j >= CW + CH + 3);
            e.pg_tag  = pg_tag;
            e.rst_tag = "R3";
            sb_q.push_back(e);
        end
    endtask

    task automatic push_warm();
        for (int j = 0; j <= H + 4; j++) begin
            exp_t e;
            e.ce   = 1'b1;
            e.pg   = 1'b1;
            e.rst  = (j >= H + 2);
            e.cpg  = 1'b1;
            e.crst = (j >= CH + 2);
            e.pg_tag  = "R5";
            e.rst_tag = "R6";
            sb_q.push_back(e);
        end
    endtask

    task automatic wait_empty();
        while (sb_q.size() > 0) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    // Monitor: one expected item per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(ce,      e.ce,   "R1", "clk_en");
                check(pg,      e.pg,   e.pg_tag, "pwr_good");
                check(rst_n,   e.rst,  e.rst_tag, "core_rst_n");
                check(c_pg,    e.cpg,  "R8", "clamped pwr_good");
                check(c_rst_n, e.crst, "R8", "clamped core_rst_n");
                check(rst_n && !pg, 1'b0, "R9", "reset released without power-good");
            end
        end
    end

    // Driver
    initial begin
        #1 cold_rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(ce,    1'b0, "R4", "reset clk_en");
        check(pg,    1'b0, "R4", "reset pwr_good");
        check(rst_n, 1'b0, "R4", "reset core_rst_n");

        // Full bring-up
        cold_rst_n = 1'b1;
        push_cold("R2");
        wait_empty();

        // Warm reset while running
        warm_rst_n = 1'b0;
        #1;
        check(rst_n, 1'b0, "R5", "async core reset on warm");
        check(pg,    1'b1, "R5", "pwr_good kept on warm");
        check(ce,    1'b1, "R5", "clk_en kept on warm");
        repeat (3) @(posedge clk);
        #1 warm_rst_n = 1'b1;
        push_warm();
        wait_empty();

        // Cold reset while running drops everything at once
        cold_rst_n = 1'b0;
        #1;
        check(ce,    1'b0, "R4", "async clk_en drop");
        check(pg,    1'b0, "R4", "async pwr_good drop");
        check(rst_n, 1'b0, "R4", "async core_rst_n drop");
        check(c_pg,  1'b0, "R4", "async clamped pwr_good drop");
        repeat (2) @(posedge clk);
        #1;
        check(pg,    1'b0, "R4", "pwr_good held in cold reset");

        // Bring-up again with a warm pulse during clock warm-up
        cold_rst_n = 1'b1;
        push_cold("R7");
        repeat (4) @(posedge clk);
        #1 warm_rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 warm_rst_n = 1'b1;
        wait_empty();

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule